// File: doc/BRIEF.md
# Transparent Translation Window Matcher

The block decides whether a memory access skips page translation. Two window configuration words are held elsewhere and presented on its inputs. Each word enables a window and qualifies the access in three ways. The first is the top byte of the address, with a per-bit don't-care mask. The second is the 3-bit access-type code, with its own per-bit don't-care mask. The third is the transfer direction, which can be ignored as a whole.

An access that falls inside any enabled window bypasses translation. The block reports that result as a flag for each window, as a combined bypass flag, and as the transparent bit of a 16-bit status word. The compare logic is purely combinational. A one-stage register with a valid handshake wraps it, so each result appears one clock after its request and stays there until the next request.

Top module: `tt_window_match`

## Requirements
- R1: A window whose enable bit (config bit 15) is 0 never reports a hit, whatever the other fields hold.
- R2: Config bits 31:24 are the address base and are compared with address bits 31:24. Config bits 23:16 are the address ignore mask: a 1 at mask bit 16+k drops address bit 24+k from the compare.
- R3: Config bits 6:4 are the code base and config bits 2:0 are the code ignore mask. A 1 at mask bit k drops code bit k from the compare.
- R4: Config bit 9 is the expected direction, with 1 meaning read and 0 meaning write, the same polarity as read_i. When config bit 8 is 1, direction is not compared.
- R5: bypass_o is 1 exactly when at least one window hits.
- R6: status_o bit 6 (transparent) equals bypass_o, and every other status bit is 0.
- R7: A request accepted with valid_i high produces valid_o high on the next clock, together with its results.
- R8: While valid_i is low, hit_o, bypass_o and status_o keep their last values, even if the other inputs change.
- R9: After reset, valid_o, hit_o, bypass_o and status_o are all 0.
- R10: hit_o[i] reflects only window i's configuration word. The windows are evaluated independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| win_cfg_i | input | NUM_WIN x 32 | Window configuration words |
| addr_i | input | 32 | Access address |
| code_i | input | 3 | Access-type code |
| read_i | input | 1 | Direction, 1 = read, 0 = write |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| hit_o | output | NUM_WIN | Per-window hit |
| bypass_o | output | 1 | Any window hit |
| status_o | output | 16 | Status word, bit 6 = transparent |

## Verification
The assertions check the following on every cycle:
- A disabled window never hits.
- The bypass flag always agrees with the per-window hits.
- The status word carries only the transparent bit.
- valid_o follows valid_i after exactly one cycle.
- The outputs hold while no request is presented.

Some behaviour only the bench's scenarios can show. This covers the field decoding itself: the address byte compare under its mask, the code compare under its mask, and the polarity and ignore flag of the direction. It also covers the independence of the two windows. The bench shows these by comparing each result against a model built from the requirements, using directed patterns and random patterns.

// File: rtl/tt_match_pkg.sv
package tt_match_pkg;
  localparam int CFG_W      = 32;
  localparam int ADDR_W     = 32;
  localparam int CODE_W     = 3;
  localparam int ABYTE_W    = 8;
  localparam int STAT_W     = 16;
  // config word field positions
  localparam int POS_ABASE  = 24;
  localparam int POS_AMASK  = 16;
  localparam int POS_EN     = 15;
  localparam int POS_DIR    = 9;
  localparam int POS_DIRIGN = 8;
  localparam int POS_CBASE  = 4;
  localparam int POS_CMASK  = 0;
  localparam int POS_TSTAT  = 6;
endpackage

// File: rtl/tt_masked_eq.sv
module tt_masked_eq #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] ign_i,
  output logic         eq_o
);
  // bit agrees or is ignored
  assign eq_o = &(~(a_i ^ b_i) | ign_i);
endmodule

// File: rtl/tt_win_match.sv
module tt_win_match
  import tt_match_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              read_i,
  output logic              hit_o
);
  logic addr_eq, code_eq, dir_eq;

  tt_masked_eq #(.W(ABYTE_W)) u_addr_eq (
    .a_i  (addr_i[ADDR_W-1 -: ABYTE_W]),
    .b_i  (cfg_i[POS_ABASE +: ABYTE_W]),
    .ign_i(cfg_i[POS_AMASK +: ABYTE_W]),
    .eq_o (addr_eq)
  );

  tt_masked_eq #(.W(CODE_W)) u_code_eq (
    .a_i  (code_i),
    .b_i  (cfg_i[POS_CBASE +: CODE_W]),
    .ign_i(cfg_i[POS_CMASK +: CODE_W]),
    .eq_o (code_eq)
  );

  tt_masked_eq #(.W(1)) u_dir_eq (
    .a_i  (read_i),
    .b_i  (cfg_i[POS_DIR]),
    .ign_i(cfg_i[POS_DIRIGN]),
    .eq_o (dir_eq)
  );

  assign hit_o = cfg_i[POS_EN] & addr_eq & code_eq & dir_eq;

  always_comb begin
    AST_DISABLED_NO_HIT: assert (cfg_i[POS_EN] !== 1'b0 || hit_o !== 1'b1); // R1
  end
endmodule

// File: rtl/tt_window_match.sv
module tt_window_match
  import tt_match_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [NUM_WIN-1:0][CFG_W-1:0] win_cfg_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CODE_W-1:0]             code_i,
  input  logic                          read_i,
  output logic                          valid_o,
  output logic [NUM_WIN-1:0]            hit_o,
  output logic                          bypass_o,
  output logic [STAT_W-1:0]             status_o
);
  logic [NUM_WIN-1:0] hit_c;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    tt_win_match u_win (
      .cfg_i (win_cfg_i[g]),
      .addr_i(addr_i),
      .code_i(code_i),
      .read_i(read_i),
      .hit_o (hit_c[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      hit_o    <= '0;
      bypass_o <= 1'b0;
      status_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hit_o    <= hit_c;
        bypass_o <= |hit_c;
        status_o <= STAT_W'(|hit_c) << POS_TSTAT;
      end
    end
  end

  AST_BYPASS_ANY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o == (|hit_o)); // R5
  AST_STATUS_TBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == (STAT_W'(bypass_o) << POS_TSTAT)); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(hit_o) && $stable(bypass_o) && $stable(status_o))); // R8
endmodule

// File: tb/tt_window_match_tb.sv
module tt_window_match_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [NW-1:0][31:0] win_cfg_i = '0;
  logic [31:0]      addr_i = '0;
  logic [2:0]       code_i = '0;
  logic             read_i = 1'b0;
  logic             valid_o;
  logic [NW-1:0]    hit_o;
  logic             bypass_o;
  logic [15:0]      status_o;

  int checks = 0;
  int errors = 0;
  logic [NW-1:0] exp_q[$];
  logic [NW-1:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tt_window_match #(.NUM_WIN(NW)) u_dut (
    .clk_i, .rst_ni, .valid_i, .win_cfg_i, .addr_i, .code_i, .read_i,
    .valid_o, .hit_o, .bypass_o, .status_o
  );

  // reference built from the field rules
  function automatic logic ref_hit(logic [31:0] c, logic [31:0] a, logic [2:0] fc, logic rd);
    logic ok;
    ok = c[15];                                    // R1
    for (int k = 0; k < 8; k++)                    // R2
      if (!c[16+k] && (a[24+k] != c[24+k])) ok = 1'b0;
    for (int k = 0; k < 3; k++)                    // R3
      if (!c[k] && (fc[k] != c[4+k])) ok = 1'b0;
    if (!c[8] && (rd != c[9])) ok = 1'b0;          // R4
    return ok;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] c0, logic [31:0] c1, logic [31:0] a, logic [2:0] fc, logic rd);
    logic [NW-1:0] e;
    @(negedge clk_i);
    win_cfg_i[0] = c0; win_cfg_i[1] = c1;
    addr_i = a; code_i = fc; read_i = rd; valid_i = 1'b1;
    e[0] = ref_hit(c0, a, fc, rd);
    e[1] = ref_hit(c1, a, fc, rd);
    exp_q.push_back(e);
    last_exp = e;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      logic [NW-1:0] e;
      if (exp_q.size() == 0) begin
        check("R7 unexpected valid_o", 32'(valid_o), 32'd0);
      end else begin
        e = exp_q.pop_front();
        check("R10/R1-R4 hit_o", 32'(hit_o), 32'(e));
        check("R5 bypass_o", 32'(bypass_o), 32'(|e));
        check("R6 status_o", 32'(status_o), 32'(16'(|e) << 6));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 valid_o", 32'(valid_o), 0);
    check("R9 hit_o", 32'(hit_o), 0);
    check("R9 bypass_o", 32'(bypass_o), 0);
    check("R9 status_o", 32'(status_o), 0);
    rst_ni = 1'b1;
    // R1 disabled window with all fields matching
    drive(32'h1200_0000 | 32'h0000_0070 | 32'h0200, 32'h0, 32'h12AB_CDEF, 3'd7, 1'b1);
    // R2 exact byte match, enabled, code and dir ignored
    drive(32'h1200_8107, 32'h0, 32'h1234_5678, 3'd2, 1'b0);
    // R2 mismatch in byte
    drive(32'h1300_8107, 32'h0, 32'h1234_5678, 3'd2, 1'b0);
    // R2 masked low nibble
    drive(32'h100F_8107, 32'h0, 32'h1B00_0000, 3'd2, 1'b0);
    // R3 code mismatch, code unmasked
    drive(32'h00FF_8150, 32'h0, 32'hFFFF_FFFF, 3'd4, 1'b1);
    drive(32'h00FF_8150, 32'h0, 32'hFFFF_FFFF, 3'd5, 1'b1);
    // R3 code bit 0 masked
    drive(32'h00FF_8151, 32'h0, 32'hFFFF_FFFF, 3'd4, 1'b1);
    // R4 direction compared: wants write
    drive(32'h00FF_8007, 32'h0, 32'h0, 3'd0, 1'b1);
    drive(32'h00FF_8007, 32'h0, 32'h0, 3'd0, 1'b0);
    // R4 wants read
    drive(32'h00FF_8207, 32'h0, 32'h0, 3'd0, 1'b1);
    // R10 only window 1 hits
    drive(32'h0000_0000, 32'hA000_8107, 32'hA000_0000, 3'd1, 1'b1);
    // R10 both hit
    drive(32'h00FF_8107, 32'hA000_8107, 32'hA000_0000, 3'd1, 1'b1);
    // R8 hold while idle with inputs changed to a miss
    @(negedge clk_i);
    win_cfg_i = '0; addr_i = 32'h5555_5555;
    repeat (3) @(negedge clk_i);
    check("R8 hit_o held", 32'(hit_o), 32'(last_exp));
    check("R8 bypass_o held", 32'(bypass_o), 32'(|last_exp));
    check("R8 status_o held", 32'(status_o), 32'(16'(|last_exp) << 6));
    check("R7 valid_o low when idle", 32'(valid_o), 0);
    // random patterns with masks leaning toward hits
    for (int i = 0; i < 60; i++) begin
      logic [31:0] c0, c1, a;
      a  = $urandom;
      c0 = $urandom; c1 = $urandom;
      if (i % 2 == 0) begin c0[31:24] = a[31:24]; c1[23:16] = 8'hFF; end
      drive(c0, c1, a, 3'($urandom), 1'($urandom));
    end
    repeat (3) @(negedge clk_i);
    check("R7 queue drained", 32'(exp_q.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule